// File: doc/BRIEF.md
# Internal Address-Space Request Translator

This block sits beside a translation unit and handles requests that target the non-memory segment. It reads a 4-bit space selector out of the virtual address and sends the request to one of three internal spaces. In the model-specific register space, a sparse architectural register number is turned into a register-file index. The index is scaled by the register width, so that no two registers share an address. In the I/O space, the two PCI configuration ports are intercepted. Every other port is passed through under a fixed I/O physical prefix.

Each request is a single-cycle pulse on `req_valid_i`. The result appears on the registered outputs one cycle later, together with `resp_valid_o`. A response carries at most one of three flags: a general-protection fault, an unsupported-space error, or a configuration-data access that has no target. When any flag is raised, the physical address is zero and the internal-register marker is low.

Top module: `ias_xlate`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after reset, `resp_valid_o`, `mmio_reg_o`, `gp_fault_o`, `space_err_o` and `no_target_o` are 0 and `paddr_o` is 0.
- R2: `resp_valid_o` is 1 exactly in the cycle after a cycle with `req_valid_i` high. In that cycle at most one of `gp_fault_o`, `space_err_o`, `no_target_o` is set. `mmio_reg_o` is set only on a response with no flag. Outside responses, all outputs are 0.
- R3: The space selector is `vaddr_i[38:35]`, which is bits 35:32 of the address shifted right by 3. Value 1 selects the register space and value 2 selects the I/O space. Value 0 (the CPUID space) and values 3 to 15 raise `space_err_o` with `paddr_o` = 0.
- R4: In the register space the register number is `vaddr_i[34:3]`. A known number sets `mmio_reg_o`, and `paddr_o` is its index times 8. The known numbers and their indices are: 0x10→1, 0x1B→2, 0xFE→3, 0x174→4, 0x175→5, 0x176→6, 0x277→7, 0xC0000080→8, 0xC0000081→9, 0xC0000100→10, 0xC0000101→11, 0xC0000102→12.
- R5: A register number that is not in the R4 list raises `gp_fault_o` with `paddr_o` = 0 and `mmio_reg_o` = 0.
- R6: In the I/O space the port is `vaddr_i[34:0]`, taken without the shift. A port with any bit of 34:16 set raises `space_err_o`.
- R7: Port 0xCF8 with `size_i` = 4 sets `mmio_reg_o`. Its `paddr_o` is 0x20 × 8 = 0x100, the scaled index of the configuration-address register.
- R8: Port 0xCF8 with any other size is handled as an ordinary port (R11).
- R9: For ports 0xCFC to 0xCFF with `cfg_addr_i[31]` = 1, `paddr_o` = 0x3000_0000_0000_0000 | (`cfg_addr_i` & 0x7FFF_FFFC) | port[1:0], and `mmio_reg_o` = 0.
- R10: For ports 0xCFC to 0xCFF with `cfg_addr_i[31]` = 0, `no_target_o` is set and `paddr_o` = 0.
- R11: Any other 16-bit port gives `paddr_o` = 0x2000_0000_0000_0000 | port, with `mmio_reg_o` = 0 and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| vaddr_i | input | 64 | Virtual address of the request |
| size_i | input | 4 | Access size in bytes |
| cfg_addr_i | input | 32 | Current PCI configuration-address register |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| paddr_o | output | 64 | Translated physical address |
| mmio_reg_o | output | 1 | Access targets an internal register |
| gp_fault_o | output | 1 | General-protection fault (error code 0) |
| space_err_o | output | 1 | Unsupported space or out-of-range port |
| no_target_o | output | 1 | Configuration-data access while the enable bit is clear |

## Verification
The block holds state only in its single response register. A wrong decode therefore shows up at the ports on the very next cycle, as a wrong physical address or a wrong flag. A stale or stuck response register shows up as a strobe, or a flag, that remains set during the idle cycle after a response. The directed tests therefore check every response, and then check that the following idle cycle is quiet. The tests also cover the edges of each decode: the first and last configuration-data ports, port 0xCF8 at an access size other than 4, the highest 16-bit port, the first out-of-range port, and register numbers that sit next to known numbers but are not themselves in the list.

// File: rtl/ias_pkg.sv
package ias_pkg;
  localparam int unsigned VA_W      = 64;
  localparam int unsigned PA_W      = 64;
  localparam int unsigned NUM_W     = 32;
  localparam int unsigned SHIFT     = 3;
  localparam int unsigned PFX_W     = 4;
  localparam int unsigned PFX_LSB   = SHIFT + NUM_W;
  localparam int unsigned PORT_W    = 16;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned REG_BYTES = 8;
  localparam int unsigned REG_SH    = $clog2(REG_BYTES);

  typedef enum logic [PFX_W-1:0] {
    SPC_CPUID = 4'd0,
    SPC_MSR   = 4'd1,
    SPC_IO    = 4'd2
  } space_e;

  typedef struct packed {
    logic            valid;
    logic [PA_W-1:0] paddr;
    logic            mmio;
    logic            gp;
    logic            err;
    logic            nt;
  } resp_t;
endpackage

// File: rtl/ias_msr_map.sv
module ias_msr_map
  import ias_pkg::*;
(
  input  logic [NUM_W-1:0] num_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b1;
    idx_o = '0;
    unique case (num_i)
      32'h0000_0010: idx_o = 8'd1;
      32'h0000_001B: idx_o = 8'd2;
      32'h0000_00FE: idx_o = 8'd3;
      32'h0000_0174: idx_o = 8'd4;
      32'h0000_0175: idx_o = 8'd5;
      32'h0000_0176: idx_o = 8'd6;
      32'h0000_0277: idx_o = 8'd7;
      32'hC000_0080: idx_o = 8'd8;
      32'hC000_0081: idx_o = 8'd9;
      32'hC000_0100: idx_o = 8'd10;
      32'hC000_0101: idx_o = 8'd11;
      32'hC000_0102: idx_o = 8'd12;
      default:       hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ias_io_map.sv
module ias_io_map
  import ias_pkg::*;
#(
  parameter logic [PA_W-1:0] IO_BASE  = 64'h2000_0000_0000_0000,
  parameter logic [PA_W-1:0] CFG_BASE = 64'h3000_0000_0000_0000,
  parameter int unsigned     CFA_IDX  = 32'h20
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [3:0]        size_i,
  input  logic [31:0]       cfg_i,
  output logic [PA_W-1:0]   paddr_o,
  output logic              mmio_o,
  output logic              nt_o
);
  localparam logic [PORT_W-1:0] CFA_PORT = 16'h0CF8;
  localparam logic [PORT_W-3:0] CFD_QUAD = 14'h033F; // 0xCFC..0xCFF

  logic is_cfa, is_cfd;
  assign is_cfa = (port_i == CFA_PORT) && (size_i == 4'd4);
  assign is_cfd = (port_i[PORT_W-1:2] == CFD_QUAD);

  always_comb begin
    paddr_o = '0;
    mmio_o  = 1'b0;
    nt_o    = 1'b0;
    if (is_cfa) begin
      mmio_o  = 1'b1;
      paddr_o = PA_W'(CFA_IDX) << REG_SH;
    end else if (is_cfd) begin
      if (cfg_i[31])
        paddr_o = CFG_BASE | PA_W'({cfg_i[30:2], port_i[1:0]});
      else
        nt_o = 1'b1;
    end else begin
      paddr_o = IO_BASE | PA_W'(port_i);
    end
  end
endmodule

// File: rtl/ias_xlate.sv
module ias_xlate
  import ias_pkg::*;
#(
  parameter logic [PA_W-1:0] IO_BASE  = 64'h2000_0000_0000_0000,
  parameter logic [PA_W-1:0] CFG_BASE = 64'h3000_0000_0000_0000,
  parameter int unsigned     CFA_IDX  = 32'h20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [3:0]      size_i,
  input  logic [31:0]     cfg_addr_i,
  output logic            resp_valid_o,
  output logic [PA_W-1:0] paddr_o,
  output logic            mmio_reg_o,
  output logic            gp_fault_o,
  output logic            space_err_o,
  output logic            no_target_o
);
  localparam int unsigned BODY_W = PFX_LSB;

  logic [PFX_W-1:0]  pfx;
  logic [NUM_W-1:0]  msr_num;
  logic [BODY_W-1:0] body;
  logic              msr_hit;
  logic [IDX_W-1:0]  msr_idx;
  logic [PA_W-1:0]   io_paddr;
  logic              io_mmio, io_nt, port_wide;
  resp_t             nxt, q;

  assign pfx       = vaddr_i[PFX_LSB +: PFX_W];
  assign msr_num   = vaddr_i[SHIFT +: NUM_W];
  assign body      = vaddr_i[BODY_W-1:0];
  assign port_wide = |body[BODY_W-1:PORT_W];

  ias_msr_map u_msr (
    .num_i (msr_num),
    .hit_o (msr_hit),
    .idx_o (msr_idx)
  );

  ias_io_map #(
    .IO_BASE  (IO_BASE),
    .CFG_BASE (CFG_BASE),
    .CFA_IDX  (CFA_IDX)
  ) u_io (
    .port_i  (body[PORT_W-1:0]),
    .size_i  (size_i),
    .cfg_i   (cfg_addr_i),
    .paddr_o (io_paddr),
    .mmio_o  (io_mmio),
    .nt_o    (io_nt)
  );

  always_comb begin
    nxt       = '0;
    nxt.valid = req_valid_i;
    if (req_valid_i) begin
      unique case (pfx)
        SPC_MSR: begin
          if (msr_hit) begin
            nxt.mmio  = 1'b1;
            nxt.paddr = PA_W'(msr_idx) << REG_SH;
          end else begin
            nxt.gp = 1'b1;
          end
        end
        SPC_IO: begin
          if (port_wide) begin
            nxt.err = 1'b1;
          end else begin
            nxt.paddr = io_paddr;
            nxt.mmio  = io_mmio;
            nxt.nt    = io_nt;
          end
        end
        default: nxt.err = 1'b1; // CPUID space and unknown selectors
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign resp_valid_o = q.valid;
  assign paddr_o      = q.paddr;
  assign mmio_reg_o   = q.mmio;
  assign gp_fault_o   = q.gp;
  assign space_err_o  = q.err;
  assign no_target_o  = q.nt;

  // R2
  resp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(resp_valid_o | mmio_reg_o | gp_fault_o | space_err_o | no_target_o));
  // R2
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gp_fault_o, space_err_o, no_target_o}));
  // R2
  mmio_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_reg_o |-> (resp_valid_o && !gp_fault_o && !space_err_o && !no_target_o));
  // R5
  fault_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gp_fault_o || space_err_o) |-> (paddr_o == '0));
  // R10
  no_target_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_target_o |-> (paddr_o == '0 && !mmio_reg_o));
endmodule

// File: tb/tb_ias_xlate.sv
module tb_ias_xlate;
  localparam logic [63:0] IO_B  = 64'h2000_0000_0000_0000;
  localparam logic [63:0] CFG_B = 64'h3000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic [3:0]  size_i = 4'd4;
  logic [31:0] cfg_addr_i = '0;
  logic        resp_valid_o, mmio_reg_o, gp_fault_o, space_err_o, no_target_o;
  logic [63:0] paddr_o;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  ias_xlate dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .vaddr_i(vaddr_i),
    .size_i(size_i), .cfg_addr_i(cfg_addr_i), .resp_valid_o(resp_valid_o),
    .paddr_o(paddr_o), .mmio_reg_o(mmio_reg_o), .gp_fault_o(gp_fault_o),
    .space_err_o(space_err_o), .no_target_o(no_target_o)
  );

  function automatic logic [63:0] mk_va(input logic [3:0] pfx, input logic [34:0] b);
    return {25'd0, pfx, b};
  endfunction

  // flags packed as {valid, mmio, gp, err, nt}
  task automatic expect_out(input string tag, input logic [4:0] ef, input logic [63:0] ea);
    logic [4:0] af;
    af = {resp_valid_o, mmio_reg_o, gp_fault_o, space_err_o, no_target_o};
    n_cmp++;
    if (af !== ef || paddr_o !== ea) begin
      n_bad++;
      $display("FAIL %s: flags=%b paddr=%h expected flags=%b paddr=%h", tag, af, paddr_o, ef, ea);
    end
  endtask

  task automatic send(input logic [63:0] va, input logic [3:0] sz, input logic [31:0] cfg,
                      input string tag, input logic [4:0] ef, input logic [63:0] ea);
    @(negedge clk);
    req_valid_i = 1'b1; vaddr_i = va; size_i = sz; cfg_addr_i = cfg;
    @(negedge clk);
    req_valid_i = 1'b0;
    expect_out(tag, ef, ea);
    @(negedge clk);
    expect_out({tag, " idle R2"}, 5'b00000, 64'd0);
  endtask

  task automatic t_reset;
    expect_out("R1 in reset", 5'b00000, 64'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset", 5'b00000, 64'd0);
  endtask

  task automatic t_msr;
    send(mk_va(4'd1, {32'h10, 3'b0}), 4'd8, 0, "R4 tsc", 5'b11000, 64'h8);
    send(mk_va(4'd1, {32'h175, 3'b0}), 4'd8, 0, "R4 0x175", 5'b11000, 64'h28);
    send(mk_va(4'd1, {32'hC000_0080, 3'b0}), 4'd8, 0, "R4 efer", 5'b11000, 64'h40);
    send(mk_va(4'd1, {32'hC000_0102, 3'b0}), 4'd8, 0, "R4 last", 5'b11000, 64'h60);
    send(mk_va(4'd1, {32'h11, 3'b0}), 4'd8, 0, "R5 unknown 0x11", 5'b10100, 64'd0);
    send(mk_va(4'd1, {32'hC000_0103, 3'b0}), 4'd8, 0, "R5 unknown hi", 5'b10100, 64'd0);
  endtask

  task automatic t_space;
    send(mk_va(4'd0, {32'h10, 3'b0}), 4'd8, 0, "R3 cpuid", 5'b10010, 64'd0);
    send(mk_va(4'd5, 35'h60), 4'd1, 0, "R3 pfx5", 5'b10010, 64'd0);
    send(mk_va(4'd15, 35'h60), 4'd1, 0, "R3 pfx15", 5'b10010, 64'd0);
    send(mk_va(4'd2, 35'h1_0000), 4'd1, 0, "R6 wide port", 5'b10010, 64'd0);
  endtask

  task automatic t_io;
    send(mk_va(4'd2, 35'hCF8), 4'd4, 0, "R7 cfa", 5'b11000, 64'h100);
    send(mk_va(4'd2, 35'hCF8), 4'd2, 0, "R8 cfa size2", 5'b10000, IO_B | 64'hCF8);
    send(mk_va(4'd2, 35'hCFE), 4'd1, 32'h8000_1234, "R9 cfd", 5'b10000, CFG_B | 64'h1236);
    send(mk_va(4'd2, 35'hCFF), 4'd1, 32'h8ABC_DEF7, "R9 cfd hi", 5'b10000, CFG_B | 64'h0ABC_DEF7);
    send(mk_va(4'd2, 35'hCFC), 4'd4, 32'h0ABC_DEF4, "R10 disabled", 5'b10001, 64'd0);
    send(mk_va(4'd2, 35'h60), 4'd1, 0, "R11 port 0x60", 5'b10000, IO_B | 64'h60);
    send(mk_va(4'd2, 35'hFFFF), 4'd2, 0, "R11 port 0xFFFF", 5'b10000, IO_B | 64'hFFFF);
    send(mk_va(4'd2, 35'hD00), 4'd4, 32'h8000_0000, "R11 past cfd", 5'b10000, IO_B | 64'hD00);
  endtask

  task automatic t_b2b;
    // R2 back-to-back requests each get their own response
    @(negedge clk);
    req_valid_i = 1'b1; vaddr_i = mk_va(4'd1, {32'h1B, 3'b0}); size_i = 4'd8;
    @(negedge clk);
    expect_out("R2 b2b first", 5'b11000, 64'h10);
    vaddr_i = mk_va(4'd2, 35'h80);
    @(negedge clk);
    req_valid_i = 1'b0;
    expect_out("R2 b2b second", 5'b10000, IO_B | 64'h80);
    @(negedge clk);
    expect_out("R2 b2b idle", 5'b00000, 64'd0);
  endtask

  initial begin
    #1;
    t_reset();
    t_msr();
    t_space();
    t_io();
    t_b2b();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule